// File: doc/BRIEF.md
# Test-Harness Termination CSR Unit

This unit gives a small RISC-V core the one control and status register that a test harness watches to decide when a program has finished. Each cycle it looks at the instruction in the execute slot. When that instruction is a CSR write to address 0x51E, it copies either the rs1 operand or a 5-bit immediate into a 32-bit register, `tohost`.

The first such write ends the run. One cycle later a sticky completion flag rises. The stored value then reads as a pass (exactly 1) or as a failure locator (any value above 1), and it stays frozen so that the harness sees the first code reported. Nothing is returned to the register file: both supported forms name x0 as their destination.

Top module: `csr_tohost_unit`

## Requirements
- R1: A write happens only for an instruction with opcode 7'b1110011, CSR address field bits 31:20 equal to 12'h51E, and rd field bits 11:7 equal to 0. Any other address, opcode or rd leaves `tohost` unchanged, and `wr_strobe` stays low.
- R2: With funct3 (bits 14:12) = 3'b001, the full 32-bit `rs1_value` is written into `tohost`.
- R3: With funct3 = 3'b101, bits 19:15 of the instruction are zero-extended to 32 bits and written into `tohost`.
- R4: Any other funct3 value, such as 3'b010 or 3'b110, causes no write.
- R5: `wr_strobe` is high, in the same cycle, exactly when a write is accepted. The new `tohost` value and `done` = 1 appear after the next rising clock edge.
- R6: Once `done` is high it stays high, and later writes are ignored: `tohost` keeps its first code and `wr_strobe` stays low.
- R7: No write occurs while `instr_valid` is low, whatever the instruction word holds.
- R8: `pass` = `done` and (`tohost` == 1). `fail` = `done` and (`tohost` > 1, unsigned). A written value of 0 sets `done` but raises neither flag.
- R9: While `rst_n` is low at a rising edge, `tohost` is cleared to 0 and `done` is cleared. `wr_strobe` is held low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction in the slot is live (not stalled or flushed) |
| instr | input | 32 | Instruction word |
| rs1_value | input | 32 | Value read from register rs1 |
| tohost | output | 32 | Current termination code register |
| wr_strobe | output | 1 | A write to the register is accepted this cycle |
| done | output | 1 | Sticky: the run has ended |
| pass | output | 1 | Run ended with code 1 |
| fail | output | 1 | Run ended with a code above 1 |

## Verification
The assertions assume that `rs1_value` belongs to the same cycle as `instr`, and that reset is held low from time zero for at least one rising edge. They also assume that inputs change only away from the rising edge. The bench drives every input on the falling edge and starts with reset asserted. Between scenarios it re-enters reset so that each termination code is checked from a clean state. It covers near-miss encodings: adjacent addresses, other funct3 values, a non-zero rd and a wrong opcode.

// File: rtl/tohost_pkg.sv
// Package: shared encodings and the decoded-instruction record for the
// termination CSR unit. Assumes 32-bit RISC-V base instruction encoding.
package tohost_pkg;

    localparam int INSTR_W = 32;

    localparam logic [6:0] OPC_SYSTEM   = 7'b1110011;
    localparam logic [2:0] F3_WRITE_REG = 3'b001;
    localparam logic [2:0] F3_WRITE_IMM = 3'b101;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_REG  = 2'd1,
        SRC_IMM  = 2'd2
    } wr_src_e;

    typedef struct packed {
        logic       hit;
        wr_src_e    src;
        logic [4:0] imm;
    } csr_dec_t;

endpackage

// File: rtl/tohost_decode.sv
// Module: tohost_decode
// Recognises the two supported CSR write forms aimed at one CSR address.
// Purely combinational. Assumes rd must be x0 (no writeback is produced).
module tohost_decode
    import tohost_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] TARGET_ADDR = 12'h51E
) (
    input  logic [INSTR_W-1:0] instr,
    output csr_dec_t           dec
);
    localparam int ADDR_LSB = INSTR_W - ADDR_W;

    logic [6:0]        opcode;
    logic [4:0]        rd_f;
    logic [2:0]        funct3;
    logic [4:0]        src_f;
    logic [ADDR_W-1:0] csr_addr;
    logic              form_ok;
    wr_src_e           src_kind;

    // Slice the instruction fields.
    always_comb begin
        opcode   = instr[6:0];
        rd_f     = instr[11:7];
        funct3   = instr[14:12];
        src_f    = instr[19:15];
        csr_addr = instr[INSTR_W-1:ADDR_LSB];
    end

    // Map funct3 onto a write source.
    always_comb begin
        unique case (funct3)
            F3_WRITE_REG: src_kind = SRC_REG;
            F3_WRITE_IMM: src_kind = SRC_IMM;
            default:      src_kind = SRC_NONE;
        endcase
    end

    // Combine opcode, destination and address match into the hit flag.
    always_comb begin
        form_ok = (opcode == OPC_SYSTEM) && (rd_f == 5'd0)
                  && (csr_addr == TARGET_ADDR[ADDR_W-1:0]);
        dec.hit = form_ok && (src_kind != SRC_NONE);
        dec.src = form_ok ? src_kind : SRC_NONE;
        dec.imm = src_f;
    end

    // r4: a hit always carries one of the two real sources.
    always_comb begin
        a_r4_hit_has_source: assert (!dec.hit || dec.src == SRC_REG || dec.src == SRC_IMM);
    end

endmodule

// File: rtl/tohost_operand.sv
// Module: tohost_operand
// Chooses the value to write: the register operand, or the immediate
// zero-extended to the data width. Assumes IMM_W < DATA_W.
module tohost_operand
    import tohost_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  wr_src_e           src,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] wdata
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-extend the immediate.
            always_comb imm_ext = {{PAD_W{1'b0}}, imm};
        end else begin : g_nopad
            // Immediate already fills the word.
            always_comb imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    // Select the write value by source.
    always_comb begin
        unique case (src)
            SRC_IMM: wdata = imm_ext;
            default: wdata = reg_val;
        endcase
    end

endmodule

// File: rtl/tohost_reg.sv
// Module: tohost_reg
// Holds the termination code and sticky done flag; derives pass/fail.
// Assumes synchronous active-low reset; accepts only the first write.
module tohost_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_take,
    output logic [DATA_W-1:0] code,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    localparam logic [DATA_W-1:0] CODE_OK = DATA_W'(1);

    // Accept a request only out of reset and before completion.
    always_comb wr_take = rst_n && wr_req && !done;

    // Register the code and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            done <= 1'b0;
        end else if (wr_take) begin
            code <= wdata;
            done <= 1'b1;
        end
    end

    // Classify the stored code.
    always_comb begin
        pass = done && (code == CODE_OK);
        fail = done && (code >  CODE_OK);
    end

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    a_r6_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(code));
    a_r5_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> done && code == $past(wdata));
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
    a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (done && code == '0) |-> !pass && !fail);

endmodule

// File: rtl/csr_tohost_unit.sv
// Module: csr_tohost_unit (top)
// Executes the register and immediate CSR write forms aimed at the
// termination register. Assumes rs1_value matches instr in the same cycle.
module csr_tohost_unit
    import tohost_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 12,
    parameter int          IMM_W       = 5,
    parameter logic [11:0] TARGET_ADDR = 12'h51E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs1_value,
    output logic [DATA_W-1:0] tohost,
    output logic              wr_strobe,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    csr_dec_t          dec;
    logic [DATA_W-1:0] wdata;
    logic              wr_req;

    tohost_decode #(
        .ADDR_W      (ADDR_W),
        .TARGET_ADDR (TARGET_ADDR)
    ) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    tohost_operand #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opnd (
        .src     (dec.src),
        .imm     (dec.imm[IMM_W-1:0]),
        .reg_val (rs1_value),
        .wdata   (wdata)
    );

    // Qualify the decoded hit with the valid flag.
    always_comb wr_req = instr_valid && dec.hit;

    tohost_reg #(
        .DATA_W (DATA_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wdata   (wdata),
        .wr_take (wr_strobe),
        .code    (tohost),
        .done    (done),
        .pass    (pass),
        .fail    (fail)
    );

    a_r7_no_write_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(tohost) && $stable(done));
    a_r1_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:20] != TARGET_ADDR[ADDR_W-1:0]) |=> $stable(tohost));
    a_r2_reg_form: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && instr[14:12] == 3'b001) |=> tohost == $past(rs1_value));
    a_r3_imm_form: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && instr[14:12] == 3'b101) |=> tohost == DATA_W'($past(instr[19:15])));

endmodule

// File: tb/sim_csr_tohost_unit.sv
module sim_csr_tohost_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_value = '0;
    logic [31:0] tohost;
    logic        wr_strobe, done, pass, fail;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_code = '0;
    logic        m_done = 1'b0;

    always #5 clk = ~clk;

    csr_tohost_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_value(rs1_value), .tohost(tohost), .wr_strobe(wr_strobe),
        .done(done), .pass(pass), .fail(fail)
    );

    function automatic logic [31:0] enc(input logic [11:0] addr, input logic [4:0] src,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] opc);
        return {addr, src, f3, rd, opc};
    endfunction

    // Behavioural expectation of an accepted write from the requirements.
    function automatic bit model_take();
        bit form;
        form = instr[6:0] == 7'h73 && instr[11:7] == 0 && instr[31:20] == 12'h51E
               && (instr[14:12] == 3'b001 || instr[14:12] == 3'b101);
        return rst_n && instr_valid && form && !m_done;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " tohost"}, tohost, m_code);
        chk({tag, " done"},   {31'd0, done}, {31'd0, m_done});
        chk({tag, " pass"},   {31'd0, pass}, {31'd0, m_done && m_code == 1});
        chk({tag, " fail"},   {31'd0, fail}, {31'd0, m_done && m_code > 1});
    endtask

    // One cycle: drive at falling edge, check strobe, clock, check state.
    task automatic step(input string tag, input logic v, input logic [31:0] ins,
                        input logic [31:0] r1);
        bit take;
        instr_valid = v; instr = ins; rs1_value = r1;
        #1;
        take = model_take();
        chk({tag, " wr_strobe (R5)"}, {31'd0, wr_strobe}, {31'd0, take});
        @(posedge clk);
        if (!rst_n) begin
            m_code = '0; m_done = 1'b0;
        end else if (take) begin
            m_code = (ins[14:12] == 3'b101) ? {27'd0, ins[19:15]} : r1;
            m_done = 1'b1;
        end
        @(negedge clk);
        chk_state(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step("R9 reset", 1'b1, enc(12'h51E, 5'd3, 3'b001, 5'd0, 7'h73), 32'h5);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        do_reset();

        // R7: valid low, matching word
        step("R7 invalid", 1'b0, enc(12'h51E, 5'd1, 3'b001, 5'd0, 7'h73), 32'h1);
        // R1: neighbouring addresses, wrong opcode, nonzero rd
        step("R1 addr 51F", 1'b1, enc(12'h51F, 5'd1, 3'b001, 5'd0, 7'h73), 32'h1);
        step("R1 addr 51C", 1'b1, enc(12'h51C, 5'd1, 3'b101, 5'd0, 7'h73), 32'h1);
        step("R1 opcode",   1'b1, enc(12'h51E, 5'd1, 3'b001, 5'd0, 7'h33), 32'h1);
        step("R1 rd",       1'b1, enc(12'h51E, 5'd1, 3'b001, 5'd4, 7'h73), 32'h1);
        // R4: other funct3 values
        step("R4 f3 010", 1'b1, enc(12'h51E, 5'd1, 3'b010, 5'd0, 7'h73), 32'h1);
        step("R4 f3 110", 1'b1, enc(12'h51E, 5'd1, 3'b110, 5'd0, 7'h73), 32'h1);
        step("R4 f3 000", 1'b1, enc(12'h51E, 5'd1, 3'b000, 5'd0, 7'h73), 32'h1);

        // R2 + R8 pass
        step("R2 reg write 1", 1'b1, enc(12'h51E, 5'd7, 3'b001, 5'd0, 7'h73), 32'h1);
        // R6: later writes ignored
        step("R6 ignored reg", 1'b1, enc(12'h51E, 5'd7, 3'b001, 5'd0, 7'h73), 32'h99);
        step("R6 ignored imm", 1'b1, enc(12'h51E, 5'd9, 3'b101, 5'd0, 7'h73), 32'h0);
        step("R6 idle", 1'b0, 32'h0, 32'h0);

        // R3 + R8 fail: max immediate, upper rs1 bits must not leak
        do_reset();
        step("R3 imm 31", 1'b1, enc(12'h51E, 5'd31, 3'b101, 5'd0, 7'h73), 32'hFFFF_FFFF);
        step("R3 hold", 1'b0, 32'h0, 32'h0);

        // R3 immediate 1 -> pass
        do_reset();
        step("R3 imm 1", 1'b1, enc(12'h51E, 5'd1, 3'b101, 5'd0, 7'h73), 32'hDEAD_BEEF);

        // R8: code 0 ends the run without pass or fail
        do_reset();
        step("R8 code 0", 1'b1, enc(12'h51E, 5'd0, 3'b101, 5'd0, 7'h73), 32'h0);
        step("R8 code 0 hold", 1'b1, enc(12'h51E, 5'd2, 3'b101, 5'd0, 7'h73), 32'h0);

        // R2 + R8: large unsigned code is a failure
        do_reset();
        step("R2 reg write big", 1'b1, enc(12'h51E, 5'd5, 3'b001, 5'd0, 7'h73), 32'h8000_0000);

        // R9: reset clears a finished run
        do_reset();
        step("R9 after reset", 1'b0, 32'h0, 32'h0);

        // assorted sweep of immediates under valid toggling (R7, R3)
        for (int i = 0; i < 32; i++) begin
            do_reset();
            step("R7 sweep invalid", 1'b0, enc(12'h51E, 5'(i), 3'b101, 5'd0, 7'h73), 32'h0);
            step("R3 sweep", 1'b1, enc(12'h51E, 5'(i), 3'b101, 5'd0, 7'h73), 32'h1234_5678);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule